// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static memory that needs no idle cycles when the bus changes between reading and writing. The model is meant for simulation. Each rising clock edge can carry one command. A command is a new address load with a direction, a continuation of the current burst, or a deselect. The data for every command crosses the bus exactly two edges after the command edge. This holds for both reads and writes, so a read can follow a write on the next cycle, and the reverse, without a gap.

A two-bit burst counter steps through a group of four words. It uses linear order or interleaved order, chosen by a static input. Each 9-bit byte lane has its own write strobe. An active-low clock enable and an active-high sleep input both freeze the whole pipeline. An asynchronous output enable gates the read driver. The data bus is modelled as a separate input port and a separate output port. The output port carries high impedance whenever it is not driven, and a separate flag marks when it is driven.

Top module: `zbt_sram`

## Requirements
- R1: After a synchronous reset, `dout_en` is low until a read completes.
- R2: A read loaded at edge k presents the addressed word on `dout` with `dout_en` high after edge k+2. The bus is not driven by that read before edge k+2.
- R3: A write loaded at edge k stores the value on `din` sampled at edge k+2. A write never drives the bus.
- R4: Bit l of `bw_n` (active low) guards bits 9l+8..9l of the word. A lane whose strobe is high keeps its old contents. Strobes have no effect on reads.
- R5: With `burst_ilv` low, burst beat n (where the load is beat 0) addresses the word whose low two bits are (start + n) mod 4. The upper bits stay fixed, and the order wraps after four beats.
- R6: With `burst_ilv` high, beat n addresses low bits start XOR (n mod 4).
- R7: A continue cycle (`ld_n` high) keeps the direction of the burst it extends. A continue with no burst in progress behaves as a deselect.
- R8: A deselect ends any burst. The bus is undriven after the second edge that follows the deselect.
- R9: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other combination with `ld_n` low is a deselect: nothing is written and nothing is read.
- R10: While `clk_en_n` is high, inputs are ignored and all state, including the output, holds as if no edge occurred. Operation resumes exactly where it stopped.
- R11: While `sleep` is high, the block behaves as under R10, and memory contents are kept.
- R12: `oe_n` high forces `dout_en` low at once, with no clock edge needed. It has no effect on writes.
- R13: Alternating writes and reads on consecutive cycles all complete, with no idle cycle between them.
- R14: The `addr` input is ignored on continue cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low |
| sleep | input | 1 | Sleep, freezes all state when high |
| ld_n | input | 1 | Low: load new command; high: continue burst |
| rd_wr | input | 1 | 1 = read, 0 = write, sampled on load |
| addr | input | AW | Word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| bw_n | input | LANES | Per-lane write strobes, active low |
| burst_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 9*LANES | Write data bus |
| dout | output | 9*LANES | Read data, high impedance when not driven |
| dout_en | output | 1 | High while `dout` is driven |

## Verification
Wrong state inside the block shows at the ports two edges after the command that exposes it. A corrupted burst counter or direction bit makes a burst read return a word from the wrong slot of the group. A stuck pipeline stage moves data by one cycle, or drives the bus during a write or deselect slot. A lost freeze lets the output change while the clock enable is high. Every address is written and read back, and every burst start is run in both orders. Every select combination and every strobe pattern is checked against a memory image kept in the bench, so each such fault shows as a mismatch within three cycles of its cause.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low address bits of a burst beat: linear adds, interleaved XORs.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] cnt,
                                               input logic       ilv);
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/zbt_burst_ctrl.sv
module zbt_burst_ctrl
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             ld_n,
    input  logic             rd_wr,
    input  logic [AW-1:0]    addr,
    input  logic             sel_ok,
    input  logic [LANES-1:0] bw_n,
    input  logic             burst_ilv,
    output op_e              iss_op,
    output logic [AW-1:0]    iss_addr,
    output logic [LANES-1:0] iss_bw_n
);

    logic          active_q;
    logic          wr_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q;
    logic [1:0]    cnt_nxt;

    assign cnt_nxt  = cnt_q + 2'd1;
    assign iss_bw_n = bw_n;

    always_comb begin
        iss_op   = OP_IDLE;
        iss_addr = addr;
        if (!ld_n) begin
            if (sel_ok)
                iss_op = rd_wr ? OP_READ : OP_WRITE;
        end else if (active_q) begin
            iss_op   = wr_q ? OP_WRITE : OP_READ;
            iss_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], cnt_nxt, burst_ilv)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (ce) begin
            if (!ld_n) begin
                active_q <= sel_ok;
                wr_q     <= ~rd_wr;
                base_q   <= addr;
                cnt_q    <= '0;
            end else if (active_q) begin
                cnt_q <= cnt_nxt;
            end
        end
    end

    // R9
    bad_select_ends_burst_chk: assert property (@(posedge clk) disable iff (rst)
        ce && !ld_n && !sel_ok |=> !active_q);

    // R5
    burst_count_steps_chk: assert property (@(posedge clk) disable iff (rst)
        ce && ld_n && active_q |=> cnt_q == $past(cnt_q) + 2'd1);

endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  op_e              in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_bw_n,
    output op_e              out_op,
    output logic [AW-1:0]    out_addr,
    output logic [LANES-1:0] out_bw_n
);

    op_e              op_q   [DEPTH];
    logic [AW-1:0]    addr_q [DEPTH];
    logic [LANES-1:0] bw_q   [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        op_e              op_src;
        logic [AW-1:0]    addr_src;
        logic [LANES-1:0] bw_src;
        if (s == 0) begin : g_head
            assign op_src   = in_op;
            assign addr_src = in_addr;
            assign bw_src   = in_bw_n;
        end else begin : g_body
            assign op_src   = op_q[s-1];
            assign addr_src = addr_q[s-1];
            assign bw_src   = bw_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                op_q[s]   <= OP_IDLE;
                addr_q[s] <= '0;
                bw_q[s]   <= '1;
            end else if (ce) begin
                op_q[s]   <= op_src;
                addr_q[s] <= addr_src;
                bw_q[s]   <= bw_src;
            end
        end
    end

    assign out_op   = op_q[DEPTH-1];
    assign out_addr = addr_q[DEPTH-1];
    assign out_bw_n = bw_q[DEPTH-1];

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  op_e                     op,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);

    localparam int WORDS = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [WORDS];
        always_ff @(posedge clk) begin
            if (ce && op == OP_WRITE && !bw_n[l])
                mem[addr] <= din[l*LANE_W +: LANE_W];
        end
        always_ff @(posedge clk) begin
            if (rst)
                rd_data[l*LANE_W +: LANE_W] <= '0;
            else if (ce && op == OP_READ)
                rd_data[l*LANE_W +: LANE_W] <= mem[addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_valid <= 1'b0;
        else if (ce)
            rd_valid <= (op == OP_READ);
    end

    // R2
    read_lands_chk: assert property (@(posedge clk) disable iff (rst)
        ce && op == OP_READ |=> rd_valid);

    // R8
    quiet_slot_floats_chk: assert property (@(posedge clk) disable iff (rst)
        ce && op != OP_READ |=> !rd_valid);

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(rd_valid) && $stable(rd_data));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 2,
    localparam int DW   = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en_n,
    input  logic             sleep,
    input  logic             ld_n,
    input  logic             rd_wr,
    input  logic [AW-1:0]    addr,
    input  logic             sel_a_n,
    input  logic             sel_b_n,
    input  logic             sel_c,
    input  logic [LANES-1:0] bw_n,
    input  logic             burst_ilv,
    input  logic             oe_n,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_en
);

    logic             ce;
    logic             sel_ok;
    op_e              iss_op;
    logic [AW-1:0]    iss_addr;
    logic [LANES-1:0] iss_bw_n;
    op_e              mem_op;
    logic [AW-1:0]    mem_addr;
    logic [LANES-1:0] mem_bw_n;
    logic [DW-1:0]    rd_data;
    logic             rd_valid;

    assign ce     = ~clk_en_n & ~sleep;
    assign sel_ok = ~sel_a_n & ~sel_b_n & sel_c;

    zbt_burst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst(rst), .ce(ce), .ld_n(ld_n), .rd_wr(rd_wr),
        .addr(addr), .sel_ok(sel_ok), .bw_n(bw_n), .burst_ilv(burst_ilv),
        .iss_op(iss_op), .iss_addr(iss_addr), .iss_bw_n(iss_bw_n)
    );

    zbt_cmd_pipe #(.AW(AW), .LANES(LANES), .DEPTH(2)) u_pipe (
        .clk(clk), .rst(rst), .ce(ce),
        .in_op(iss_op), .in_addr(iss_addr), .in_bw_n(iss_bw_n),
        .out_op(mem_op), .out_addr(mem_addr), .out_bw_n(mem_bw_n)
    );

    zbt_lane_array #(.AW(AW), .LANES(LANES)) u_array (
        .clk(clk), .rst(rst), .ce(ce), .op(mem_op), .addr(mem_addr),
        .bw_n(mem_bw_n), .din(din), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign dout_en = rd_valid & ~oe_n;
    assign dout    = dout_en ? rd_data : {DW{1'bz}};

    // R7
    orphan_continue_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ce && ld_n && !u_ctrl.active_q |-> iss_op == OP_IDLE);

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
    import zbt_pkg::*;

    localparam int AW = 6, LANES = 2, DW = 18, WORDS = 64, MAXS = 256;

    logic clk = 1'b0;
    logic rst = 1'b1, clk_en_n = 1'b0, sleep = 1'b0, ld_n = 1'b0, rd_wr = 1'b1;
    logic sel_a_n = 1'b1, sel_b_n = 1'b0, sel_c = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [LANES-1:0] bw_n = '0;
    logic [DW-1:0]    din  = '0;
    wire  [DW-1:0]    dout;
    wire              dout_en;

    zbt_sram #(.AW(AW), .LANES(LANES)) uut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sleep(sleep), .ld_n(ld_n),
        .rd_wr(rd_wr), .addr(addr), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .sel_c(sel_c), .bw_n(bw_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slot program and expectations
    int               n = 0;
    logic             s_ld_n [MAXS];
    logic             s_rw   [MAXS];
    logic [AW-1:0]    s_addr [MAXS];
    logic [2:0]       s_sel  [MAXS];
    logic [1:0]       s_bw   [MAXS];
    logic [DW-1:0]    s_din  [MAXS];
    bit               s_drv  [MAXS];
    logic [DW-1:0]    s_exp  [MAXS];
    string            s_req  [MAXS];
    logic [DW-1:0]    shadow [WORDS];

    bit               m_act = 0, m_wr = 0;
    logic [AW-1:0]    m_base = '0;
    logic [1:0]       m_cnt = '0;

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 32'h2b9 + salt * 32'h1d3) ^ 32'h15a5a);
    endfunction

    function automatic logic [1:0] order_lo(input logic [1:0] st, input logic [1:0] k, input bit ilv);
        return ilv ? (st ^ k) : 2'((int'(st) + int'(k)) % 4);
    endfunction

    task automatic apply(input bit is_wr, input logic [AW-1:0] a, input logic [1:0] bw, input logic [DW-1:0] d);
        if (is_wr) begin
            for (int l = 0; l < LANES; l++)
                if (!bw[l]) shadow[a][l*9 +: 9] = d[l*9 +: 9];
            s_drv[n] = 0;
        end else begin
            s_drv[n] = 1;
            s_exp[n] = shadow[a];
        end
    endtask

    task automatic add_load(input bit is_read, input logic [AW-1:0] a, input logic [1:0] bw,
                            input logic [DW-1:0] d, input string req);
        s_ld_n[n] = 0; s_rw[n] = is_read; s_addr[n] = a; s_sel[n] = 3'b001;
        s_bw[n] = bw; s_din[n] = d; s_req[n] = req;
        m_act = 1; m_wr = !is_read; m_base = a; m_cnt = 0;
        apply(!is_read, a, bw, d);
        n++;
    endtask

    task automatic add_cont(input logic [AW-1:0] junk, input logic [1:0] bw,
                            input logic [DW-1:0] d, input string req);
        s_ld_n[n] = 1; s_rw[n] = ~m_wr; s_addr[n] = junk; s_sel[n] = 3'b001;
        s_bw[n] = bw; s_din[n] = d; s_req[n] = req;
        if (m_act) begin
            m_cnt = m_cnt + 2'd1;
            apply(m_wr, {m_base[AW-1:2], order_lo(m_base[1:0], m_cnt, burst_ilv)}, bw, d);
        end else begin
            s_drv[n] = 0;
        end
        n++;
    endtask

    // A load with a failing select code: a deselect, nothing written
    task automatic add_desel(input logic [2:0] sel, input bit is_read, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input string req);
        s_ld_n[n] = 0; s_rw[n] = is_read; s_addr[n] = a; s_sel[n] = sel;
        s_bw[n] = 2'b00; s_din[n] = d; s_req[n] = req; s_drv[n] = 0;
        m_act = 0;
        n++;
    endtask

    task automatic drive_idle();
        ld_n = 0; sel_a_n = 1; sel_b_n = 0; sel_c = 1; rd_wr = 1; bw_n = '1;
    endtask

    task automatic run_seq();
        for (int t = 0; t < n + 3; t++) begin
            @(negedge clk);
            if (t >= 3) begin
                if (s_drv[t-3])
                    check(dout_en === 1'b1 && dout === s_exp[t-3], s_req[t-3], {dout_en, 13'd0, dout}, {1'b1, 13'd0, s_exp[t-3]});
                else
                    check(dout_en === 1'b0, s_req[t-3], 32'(dout_en), 32'd0);
            end
            if (t < n) begin
                ld_n = s_ld_n[t]; rd_wr = s_rw[t]; addr = s_addr[t];
                {sel_a_n, sel_b_n, sel_c} = s_sel[t]; bw_n = s_bw[t];
            end else begin
                drive_idle();
            end
            din = (t >= 2 && t - 2 < n) ? s_din[t-2] : '0;
        end
        n = 0;
        m_act = 0;
    endtask

    task automatic freeze_test(input bit use_sleep, input logic [AW-1:0] a, input string req);
        logic [DW-1:0] keep;
        keep = shadow[a];
        @(negedge clk); ld_n = 0; rd_wr = 1; addr = a; {sel_a_n, sel_b_n, sel_c} = 3'b001;
        @(negedge clk); drive_idle();
        @(negedge clk);
        if (use_sleep) sleep = 1; else clk_en_n = 1;
        ld_n = 0; rd_wr = 0; addr = a; {sel_a_n, sel_b_n, sel_c} = 3'b001; bw_n = '0; din = ~keep;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(dout_en === 1'b0, {req, " nothing moves while frozen"}, 32'(dout_en), 32'd0);
        end
        sleep = 0; clk_en_n = 0; drive_idle(); din = '0;
        @(negedge clk);
        check(dout_en === 1'b1 && dout === keep, {req, " read resumes"}, 32'(dout), 32'(keep));
        if (use_sleep) sleep = 1; else clk_en_n = 1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(dout_en === 1'b1 && dout === keep, {req, " output held"}, 32'(dout), 32'(keep));
        end
        sleep = 0; clk_en_n = 0;
        @(negedge clk);
        check(dout_en === 1'b0, {req, " deselect after resume"}, 32'(dout_en), 32'd0);
        add_load(1, a, 2'b00, '0, {req, " no write while frozen"});
        run_seq();
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < WORDS; a++) shadow[a] = '0;
        drive_idle();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(dout_en === 1'b0, "R1 bus idle after reset", 32'(dout_en), 32'd0);

        // R2 R3: every address written then read back
        for (int a = 0; a < WORDS; a++) add_load(0, AW'(a), 2'b00, pat(a, 1), "R3 write sweep");
        for (int a = 0; a < WORDS; a++) add_load(1, AW'(a), 2'b11, '0, "R2 read sweep");
        run_seq();

        // R13: write then read of the same word on back-to-back cycles
        for (int a = 0; a < 16; a++) begin
            add_load(0, AW'(a * 3), 2'b00, pat(a, 7), "R13 write slot");
            add_load(1, AW'(a * 3), 2'b00, '0, "R13 read right after write");
        end
        run_seq();

        // R4: every strobe pattern
        for (int b = 0; b < 4; b++) begin
            add_load(0, AW'(40 + b), 2'(b), pat(b, 11), "R4 lane write");
            add_load(1, AW'(40 + b), 2'(b), '0, "R4 lane readback");
        end
        run_seq();

        // R5 R6 R14: bursts from each start in both orders
        for (int ilv = 0; ilv < 2; ilv++) begin
            burst_ilv = 1'(ilv);
            for (int st = 0; st < 4; st++) begin
                logic [AW-1:0] base;
                base = {4'(8 + ilv), 2'(st)};
                add_load(0, base, 2'b00, pat(st, 20 + ilv), ilv ? "R6 burst write" : "R5 burst write");
                for (int k = 1; k < 4; k++)
                    add_cont(~base, 2'b00, pat(st * 4 + k, 30 + ilv), ilv ? "R6 R14 burst write beat" : "R5 R14 burst write beat");
                for (int w = 0; w < 4; w++)
                    add_load(1, {base[AW-1:2], 2'(w)}, 2'b00, '0, ilv ? "R6 word placement" : "R5 word placement");
                add_load(1, base, 2'b00, '0, ilv ? "R6 burst read" : "R5 burst read");
                for (int k = 1; k < 5; k++)
                    add_cont(AW'(k * 13), 2'b00, '0, ilv ? "R6 R14 burst read beat" : "R5 R14 burst read beat wrap");
                run_seq();
            end
        end
        burst_ilv = 0;

        // R7 R8: direction inheritance and orphan continues
        add_load(1, AW'(4), 2'b00, '0, "R7 read load");
        add_cont(AW'(0), 2'b00, '0, "R7 continue stays read");
        add_desel(3'b101, 1, AW'(4), '0, "R8 deselect ends burst");
        add_cont(AW'(4), 2'b00, '0, "R7 R8 orphan continue");
        add_cont(AW'(4), 2'b00, 18'h3ffff, "R7 orphan continue");
        add_load(1, AW'(5), 2'b00, '0, "R7 word untouched by orphan");
        add_load(0, AW'(48), 2'b00, pat(48, 3), "R7 write load");
        add_cont(AW'(0), 2'b10, pat(49, 3), "R7 continue stays write");
        add_load(1, AW'(48), 2'b00, '0, "R7 readback");
        add_load(1, AW'(49), 2'b00, '0, "R7 readback");
        run_seq();

        // R9: all failing select codes, write and read
        for (int c = 0; c < 8; c++) begin
            if (c != 1) begin
                add_desel(3'(c), 0, AW'(50), 18'h2aaaa, "R9 bad select write");
                add_desel(3'(c), 1, AW'(50), '0, "R9 bad select read");
            end
        end
        add_load(1, AW'(50), 2'b00, '0, "R9 word unchanged");
        run_seq();

        // R10 R11
        freeze_test(0, AW'(9), "R10");
        freeze_test(1, AW'(10), "R11");

        // R12: asynchronous output enable
        @(negedge clk); ld_n = 0; rd_wr = 1; addr = AW'(11); {sel_a_n, sel_b_n, sel_c} = 3'b001;
        @(negedge clk); drive_idle();
        @(negedge clk);
        @(negedge clk);
        check(dout_en === 1'b1 && dout === shadow[11], "R12 read driven", 32'(dout), 32'(shadow[11]));
        oe_n = 1; #1;
        check(dout_en === 1'b0, "R12 oe high floats at once", 32'(dout_en), 32'd0);
        oe_n = 0; #1;
        check(dout_en === 1'b1, "R12 oe low drives again", 32'(dout_en), 32'd1);
        oe_n = 1;
        add_load(0, AW'(12), 2'b00, pat(12, 99), "R12 write with oe high");
        add_load(1, AW'(12), 2'b00, '0, "R12 read with oe high");
        s_drv[n-1] = 0;
        run_seq();
        oe_n = 0;
        add_load(1, AW'(12), 2'b00, '0, "R12 write landed");
        run_seq();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule